// File: doc/BRIEF.md
# Supply Trip-Threshold Programming Command Decoder

This block is the serial front end of a supply supervisor that also holds a nonvolatile memory. It receives the usual four-wire serial bus signals (clock, active-low select, data in), oversamples them on the system clock and splits each select-low frame into bytes. It recognises two commands: the write-enable command, which arms a write-enable latch, and the write command, which carries a two-byte address and then data bytes.

In the normal case the data bytes of an enabled write go out one at a time on a memory-side port. Each byte carries an address that wraps inside its 64-byte page. A commit pulse follows when the frame ends cleanly. There is also a digital input that reports a programming voltage on the write-protect pin. While it is high, an enabled write of a single 00h byte to address 0001h or 0003h changes meaning. It no longer touches memory and instead becomes a one-cycle request: 0001h moves the supply trip threshold to a new level, and 0003h returns it to its native level. Every request is issued only when select rises, never while the frame is still running.

Top module: `trip_prog_spi`

## Requirements
- R1: After reset no frame is decoded until the select input has been seen high and then low. Bits clocked while select stays low from reset are ignored, and the write-enable latch stays 0.
- R2: Serial data is sampled on serial-clock rising edges, most significant bit first, with the clock idling low (mode 0) or high (mode 3).
- R3: Write-enable code 06h, followed by select rising exactly after those 8 bits, sets `wr_en_latch`. If the frame holds any further bits the latch is left unchanged.
- R4: A write (code 02h, then address high byte, then address low byte, then data) that arrives while `wr_en_latch` is 0 is ignored. Nothing is forwarded, no pulse is raised and the latch stays 0.
- R5: In an enabled memory write, each data byte is forwarded with a one-cycle `mem_wr_valid`. Address bits 15:6 are kept and bits 5:0 start at the sent value, then increment modulo 64, so 007Eh is followed by 007Fh, 0040h, 0041h.
- R6: A memory write whose frame ends on a byte boundary after at least one data byte raises `mem_commit` for one cycle and clears `wr_en_latch`.
- R7: With `vprog_hi` high through the frame, an enabled write to address 0001h holding exactly one data byte 00h gives a single-cycle `trip_set_p` after select rises. It also clears the latch and forwards no byte.
- R8: The same sequence to address 0003h gives a single-cycle `trip_native_p` instead.
- R9: A write to 0001h or 0003h under `vprog_hi` with a data value other than 00h, or with more than one data byte, is discarded. No pulse is raised, no byte is forwarded and the latch is kept.
- R10: A write frame that ends in the middle of a byte, or before any data byte, raises no commit or trip pulse and keeps the latch. Bytes already forwarded stay forwarded.
- R11: Any other first byte makes the frame ignored, and the latch keeps its value.
- R12: `trip_set_p`, `trip_native_p` and `mem_commit` are never high together. Each one follows a frame end.
- R13: While reset is active and just after it, `wr_en_latch`, `trip_set_p`, `trip_native_p`, `mem_wr_valid` and `mem_commit` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_si | input | 1 | Serial data in |
| vprog_hi | input | 1 | High while the programming voltage is on the write-protect pin |
| wr_en_latch | output | 1 | Write-enable latch state |
| trip_set_p | output | 1 | One-cycle request to program a new trip level |
| trip_native_p | output | 1 | One-cycle request to restore the native trip level |
| mem_wr_valid | output | 1 | One-cycle strobe for each forwarded data byte |
| mem_wr_addr | output | 16 | Page-wrapped address of the forwarded byte |
| mem_wr_data | output | 8 | Forwarded data byte |
| mem_commit | output | 1 | One-cycle pulse closing a valid memory write |

## Verification
The assertions assume that each serial-clock phase and each select level lasts several system-clock cycles. Under that assumption a frame end never lands in the same cycle as the last sample of a byte. They also assume `vprog_hi` holds still from the address bytes to the end of the frame. The stimulus keeps every bus half-period at five system cycles and leaves a gap after each select rise. It changes `vprog_hi` only between frames, and it alternates mode 0 and mode 3 frames.

// File: rtl/tp_pkg.sv
package tp_pkg;
  localparam logic [7:0]  OPC_WREN         = 8'h06;
  localparam logic [7:0]  OPC_WRITE        = 8'h02;
  localparam logic [15:0] ADDR_TRIP_SET    = 16'h0001;
  localparam logic [15:0] ADDR_TRIP_NATIVE = 16'h0003;
  localparam logic [7:0]  TRIP_DATA        = 8'h00;
  localparam int          ADDR_W           = 16;

  typedef enum logic [2:0] {
    S_IDLE, S_OPC, S_WREN, S_AHI, S_ALO, S_DATA, S_SKIP
  } dec_state_t;

  typedef enum logic [1:0] {
    M_MEM, M_SET, M_NATIVE
  } wr_mode_t;
endpackage

// File: rtl/tp_sync.sv
module tp_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    if (k == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[k] <= '0;
        else        stg[k] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[k] <= '0;
        else        stg[k] <= stg[k-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/tp_frame.sv
module tp_frame (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sck_s,
  input  logic       cs_n_s,
  input  logic       si_s,
  output logic       frame_start,
  output logic       frame_end,
  output logic       byte_done,
  output logic [7:0] byte_data,
  output logic       mid_byte
);
  logic       sck_q, cs_q, in_frame;
  logic [2:0] bit_cnt;
  logic [7:0] shreg;

  logic       sck_q_n, cs_q_n, in_frame_n;
  logic [2:0] bit_cnt_n;
  logic [7:0] shreg_n, byte_data_n;
  logic       frame_start_n, frame_end_n, byte_done_n;
  logic       cs_fall, cs_rise, sck_rise, sample;

  always_comb begin
    cs_fall  = cs_q & ~cs_n_s;
    cs_rise  = ~cs_q & cs_n_s;
    sck_rise = ~sck_q & sck_s;
    sample   = in_frame & ~cs_n_s & sck_rise;

    sck_q_n       = sck_s;
    cs_q_n        = cs_n_s;
    in_frame_n    = in_frame;
    bit_cnt_n     = bit_cnt;
    shreg_n       = shreg;
    byte_data_n   = byte_data;
    byte_done_n   = 1'b0;
    frame_start_n = cs_fall;
    frame_end_n   = cs_rise & in_frame;

    if (cs_fall) begin
      in_frame_n = 1'b1;
      bit_cnt_n  = 3'd0;
    end else if (cs_rise) begin
      in_frame_n = 1'b0;
    end else if (sample) begin
      bit_cnt_n = bit_cnt + 3'd1;
      shreg_n   = {shreg[6:0], si_s};
      if (bit_cnt == 3'd7) begin
        byte_done_n = 1'b1;
        byte_data_n = {shreg[6:0], si_s};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q       <= 1'b0;
      cs_q        <= 1'b0;
      in_frame    <= 1'b0;
      bit_cnt     <= 3'd0;
      shreg       <= 8'd0;
      byte_data   <= 8'd0;
      byte_done   <= 1'b0;
      frame_start <= 1'b0;
      frame_end   <= 1'b0;
    end else begin
      sck_q       <= sck_q_n;
      cs_q        <= cs_q_n;
      in_frame    <= in_frame_n;
      bit_cnt     <= bit_cnt_n;
      shreg       <= shreg_n;
      byte_data   <= byte_data_n;
      byte_done   <= byte_done_n;
      frame_start <= frame_start_n;
      frame_end   <= frame_end_n;
    end
  end

  assign mid_byte = (bit_cnt != 3'd0);

  // R1: a new frame always begins on a byte boundary
  p_start_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> !mid_byte);
  // R2: assembled bytes only appear inside a selected frame
  p_byte_in_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |-> in_frame);
endmodule

// File: rtl/tp_decoder.sv
module tp_decoder
  import tp_pkg::*;
#(
  parameter int PAGE_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              frame_end,
  input  logic              byte_done,
  input  logic [7:0]        byte_data,
  input  logic              mid_byte,
  input  logic              hv_s,
  output logic              wel,
  output logic              trip_set,
  output logic              trip_native,
  output logic              mem_wr_valid,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [7:0]        mem_wr_data,
  output logic              mem_commit
);
  localparam int OFF_W = $clog2(PAGE_BYTES);

  dec_state_t        state, state_n;
  wr_mode_t          mode, mode_n;
  logic              wel_n;
  logic [ADDR_W-1:0] addr_q, addr_n, full_addr;
  logic [1:0]        data_cnt, data_cnt_n;
  logic [7:0]        first_data, first_data_n;
  logic [OFF_W-1:0]  off_q, off_n;
  logic              trip_set_n, trip_native_n, valid_n, commit_n;
  logic [ADDR_W-1:0] waddr_n;
  logic [7:0]        wdata_n;

  always_comb begin
    state_n       = state;
    mode_n        = mode;
    wel_n         = wel;
    addr_n        = addr_q;
    data_cnt_n    = data_cnt;
    first_data_n  = first_data;
    off_n         = off_q;
    trip_set_n    = 1'b0;
    trip_native_n = 1'b0;
    valid_n       = 1'b0;
    commit_n      = 1'b0;
    waddr_n       = mem_wr_addr;
    wdata_n       = mem_wr_data;
    full_addr     = {addr_q[ADDR_W-1:8], byte_data};

    if (frame_start) begin
      state_n = S_OPC;
    end else if (frame_end) begin
      state_n = S_IDLE;
      if (!mid_byte) begin
        case (state)
          S_WREN: wel_n = 1'b1;
          S_DATA: begin
            if (data_cnt != 2'd0) begin
              if (mode == M_MEM) begin
                commit_n = 1'b1;
                wel_n    = 1'b0;
              end else if (data_cnt == 2'd1 && first_data == TRIP_DATA && hv_s) begin
                trip_set_n    = (mode == M_SET);
                trip_native_n = (mode == M_NATIVE);
                wel_n         = 1'b0;
              end
            end
          end
          default: ;
        endcase
      end
    end else if (byte_done) begin
      case (state)
        S_OPC: begin
          if (byte_data == OPC_WREN)       state_n = S_WREN;
          else if (byte_data == OPC_WRITE) state_n = S_AHI;
          else                             state_n = S_SKIP;
        end
        S_WREN: state_n = S_SKIP;
        S_AHI: begin
          addr_n[ADDR_W-1:8] = byte_data;
          state_n            = S_ALO;
        end
        S_ALO: begin
          addr_n[7:0] = byte_data;
          if (!wel) begin
            state_n = S_SKIP;
          end else begin
            state_n    = S_DATA;
            data_cnt_n = 2'd0;
            off_n      = byte_data[OFF_W-1:0];
            if (hv_s && full_addr == ADDR_TRIP_SET)         mode_n = M_SET;
            else if (hv_s && full_addr == ADDR_TRIP_NATIVE) mode_n = M_NATIVE;
            else                                            mode_n = M_MEM;
          end
        end
        S_DATA: begin
          if (data_cnt != 2'd2) data_cnt_n = data_cnt + 2'd1;
          if (data_cnt == 2'd0) first_data_n = byte_data;
          if (mode == M_MEM) begin
            valid_n = 1'b1;
            waddr_n = {addr_q[ADDR_W-1:OFF_W], off_q};
            wdata_n = byte_data;
            off_n   = off_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= S_IDLE;
      mode         <= M_MEM;
      wel          <= 1'b0;
      addr_q       <= '0;
      data_cnt     <= 2'd0;
      first_data   <= 8'd0;
      off_q        <= '0;
      trip_set     <= 1'b0;
      trip_native  <= 1'b0;
      mem_wr_valid <= 1'b0;
      mem_wr_addr  <= '0;
      mem_wr_data  <= 8'd0;
      mem_commit   <= 1'b0;
    end else begin
      state        <= state_n;
      mode         <= mode_n;
      wel          <= wel_n;
      addr_q       <= addr_n;
      data_cnt     <= data_cnt_n;
      first_data   <= first_data_n;
      off_q        <= off_n;
      trip_set     <= trip_set_n;
      trip_native  <= trip_native_n;
      mem_wr_valid <= valid_n;
      mem_wr_addr  <= waddr_n;
      mem_wr_data  <= wdata_n;
      mem_commit   <= commit_n;
    end
  end

  p_one_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({trip_set, trip_native, mem_commit}));
  p_set_after_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trip_set |-> $past(frame_end));
  p_set_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trip_set |=> !trip_set);
  p_native_after_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    trip_native |-> $past(frame_end));
  p_fwd_needs_wel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid |-> wel);
  p_commit_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_commit |-> !wel);
  p_wel_rise_on_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> $past(frame_end));
endmodule

// File: rtl/trip_prog_spi.sv
module trip_prog_spi #(
  parameter int PAGE_BYTES  = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        spi_sck,
  input  logic        spi_cs_n,
  input  logic        spi_si,
  input  logic        vprog_hi,
  output logic        wr_en_latch,
  output logic        trip_set_p,
  output logic        trip_native_p,
  output logic        mem_wr_valid,
  output logic [15:0] mem_wr_addr,
  output logic [7:0]  mem_wr_data,
  output logic        mem_commit
);
  logic [3:0] pins_s;
  logic       frame_start, frame_end, byte_done, mid_byte;
  logic [7:0] byte_data;

  tp_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({vprog_hi, spi_sck, spi_cs_n, spi_si}),
    .q     (pins_s)
  );

  tp_frame u_frame (
    .clk         (clk),
    .rst_n       (rst_n),
    .sck_s       (pins_s[2]),
    .cs_n_s      (pins_s[1]),
    .si_s        (pins_s[0]),
    .frame_start (frame_start),
    .frame_end   (frame_end),
    .byte_done   (byte_done),
    .byte_data   (byte_data),
    .mid_byte    (mid_byte)
  );

  tp_decoder #(.PAGE_BYTES(PAGE_BYTES)) u_dec (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_start  (frame_start),
    .frame_end    (frame_end),
    .byte_done    (byte_done),
    .byte_data    (byte_data),
    .mid_byte     (mid_byte),
    .hv_s         (pins_s[3]),
    .wel          (wr_en_latch),
    .trip_set     (trip_set_p),
    .trip_native  (trip_native_p),
    .mem_wr_valid (mem_wr_valid),
    .mem_wr_addr  (mem_wr_addr),
    .mem_wr_data  (mem_wr_data),
    .mem_commit   (mem_commit)
  );
endmodule

// File: tb/sim_trip_prog_spi.sv
module sim_trip_prog_spi;
  localparam int HALF = 5;
  localparam int NV   = 14;
  // fields: wren hv opc addr nbytes dval extra | exp set nat commit fwd wel
  localparam logic [46:0] VEC [NV] = '{
    {1'b1,1'b0,8'h02,16'h0120,3'd3,8'hA0,3'd0, 1'b0,1'b0,1'b1,3'd3,1'b0}, // R5 R6
    {1'b1,1'b1,8'h02,16'h0001,3'd1,8'h00,3'd0, 1'b1,1'b0,1'b0,3'd0,1'b0}, // R7
    {1'b1,1'b1,8'h02,16'h0003,3'd1,8'h00,3'd0, 1'b0,1'b1,1'b0,3'd0,1'b0}, // R8
    {1'b1,1'b0,8'h02,16'h0001,3'd1,8'h00,3'd0, 1'b0,1'b0,1'b1,3'd1,1'b0}, // no voltage: memory
    {1'b0,1'b0,8'h02,16'h0040,3'd2,8'h10,3'd0, 1'b0,1'b0,1'b0,3'd0,1'b0}, // R4
    {1'b1,1'b1,8'h02,16'h0001,3'd1,8'h05,3'd0, 1'b0,1'b0,1'b0,3'd0,1'b1}, // R9 value
    {1'b0,1'b1,8'h02,16'h0003,3'd2,8'h00,3'd0, 1'b0,1'b0,1'b0,3'd0,1'b1}, // R9 count
    {1'b0,1'b0,8'h02,16'h0200,3'd2,8'h30,3'd3, 1'b0,1'b0,1'b0,3'd2,1'b1}, // R10 mid-byte
    {1'b0,1'b0,8'h02,16'h0300,3'd1,8'h44,3'd0, 1'b0,1'b0,1'b1,3'd1,1'b0}, // R6
    {1'b1,1'b1,8'h02,16'h0002,3'd1,8'h11,3'd0, 1'b0,1'b0,1'b1,3'd1,1'b0}, // other address
    {1'b1,1'b0,8'h03,16'h0000,3'd1,8'h00,3'd0, 1'b0,1'b0,1'b0,3'd0,1'b1}, // R11
    {1'b0,1'b1,8'h02,16'h0003,3'd1,8'h00,3'd0, 1'b0,1'b1,1'b0,3'd0,1'b0}, // R8
    {1'b1,1'b0,8'h02,16'h0010,3'd0,8'h00,3'd0, 1'b0,1'b0,1'b0,3'd0,1'b1}, // R10 no data
    {1'b0,1'b1,8'h02,16'h0001,3'd1,8'h00,3'd0, 1'b1,1'b0,1'b0,3'd0,1'b0}  // R7
  };

  logic clk = 1'b0;
  logic rst_n, sck, cs_n, si, hv;
  logic wel, tset, tnat, wvalid, commit;
  logic [15:0] waddr;
  logic [7:0]  wdata;

  int total = 0, bad = 0, cycles = 0;
  int n_set = 0, n_nat = 0, n_com = 0, n_fwd = 0;
  logic [15:0] log_a [32];
  logic [7:0]  log_d [32];

  always #2 clk = ~clk;

  trip_prog_spi u0 (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_si(si),
    .vprog_hi(hv), .wr_en_latch(wel), .trip_set_p(tset), .trip_native_p(tnat),
    .mem_wr_valid(wvalid), .mem_wr_addr(waddr), .mem_wr_data(wdata),
    .mem_commit(commit)
  );

  always @(negedge clk) begin
    cycles <= cycles + 1;
    if (rst_n) begin
      if (tset)   n_set <= n_set + 1;
      if (tnat)   n_nat <= n_nat + 1;
      if (commit) n_com <= n_com + 1;
      if (wvalid) begin
        if (n_fwd < 32) begin
          log_a[n_fwd] <= waddr;
          log_d[n_fwd] <= wdata;
        end
        n_fwd <= n_fwd + 1;
      end
    end
    if (cycles > 150000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bits(input bit m3, input logic [7:0] v, input int n);
    for (int k = 7; k > 7 - n; k--) begin
      if (m3) sck = 1'b0;
      si = v[k];
      wait_n(HALF);
      sck = 1'b1;
      wait_n(HALF);
      if (!m3) sck = 1'b0;
    end
  endtask

  task automatic open_f(input bit m3);
    sck = m3;
    wait_n(HALF);
    cs_n = 1'b0;
    wait_n(HALF);
  endtask

  task automatic close_f();
    wait_n(HALF);
    cs_n = 1'b1;
    wait_n(30);
  endtask

  task automatic send_wren(input bit m3);
    open_f(m3);
    bits(m3, 8'h06, 8);
    close_f();
  endtask

  initial begin
    rst_n = 1'b0; sck = 1'b0; cs_n = 1'b0; si = 1'b0; hv = 1'b0;
    wait_n(6);
    // R13: quiet outputs right after reset
    chk("R13 wel", int'(wel), 0);
    chk("R13 pulses", int'({tset, tnat, wvalid, commit}), 0);
    rst_n = 1'b1;
    wait_n(3);
    chk("R13 after release", int'({wel, tset, tnat, wvalid, commit}), 0);

    // R1: select low since reset, write-enable clocked in must not count
    bits(1'b0, 8'h06, 8);
    wait_n(HALF);
    cs_n = 1'b1;
    wait_n(30);
    chk("R1 no frame before select fall", int'(wel), 0);

    for (int i = 0; i < NV; i++) begin
      automatic logic [46:0] v = VEC[i];
      automatic bit m3 = i[0];
      automatic int s0 = n_set, a0 = n_nat, c0 = n_com, f0 = n_fwd;
      hv = v[45];
      if (v[46]) begin
        send_wren(m3);
        chk("R3 write enable set", int'(wel), 1);
      end
      open_f(m3);
      bits(m3, v[44:37], 8);
      bits(m3, v[36:29], 8);
      bits(m3, v[28:21], 8);
      for (int b = 0; b < int'(v[20:18]); b++) bits(m3, v[17:10] + 8'(b), 8);
      if (v[9:7] != 3'd0) bits(m3, 8'hFF, int'(v[9:7]));
      close_f();
      hv = 1'b0;
      chk($sformatf("R7 set count vec%0d", i), n_set - s0, int'(v[6]));
      chk($sformatf("R8 native count vec%0d", i), n_nat - a0, int'(v[5]));
      chk($sformatf("R6 commit count vec%0d", i), n_com - c0, int'(v[4]));
      chk($sformatf("R5 forward count vec%0d", i), n_fwd - f0, int'(v[3:1]));
      chk($sformatf("R3 latch after vec%0d", i), int'(wel), int'(v[0]));
      if (v[3:1] != 3'd0 && f0 < 32) begin
        chk($sformatf("R5 first address vec%0d", i), int'(log_a[f0]), int'(v[36:21]));
        chk($sformatf("R2 first data vec%0d", i), int'(log_d[f0]), int'(v[17:10]));
      end
    end

    // R5: page wrap from 007Eh
    begin
      automatic int f0 = n_fwd;
      send_wren(1'b1);
      open_f(1'b1);
      bits(1'b1, 8'h02, 8);
      bits(1'b1, 8'h00, 8);
      bits(1'b1, 8'h7E, 8);
      for (int b = 0; b < 4; b++) bits(1'b1, 8'h50 + 8'(b), 8);
      close_f();
      chk("R5 wrap count", n_fwd - f0, 4);
      if (n_fwd - f0 == 4 && f0 + 4 <= 32) begin
        chk("R5 addr 0", int'(log_a[f0]),   16'h007E);
        chk("R5 addr 1", int'(log_a[f0+1]), 16'h007F);
        chk("R5 addr 2 wraps", int'(log_a[f0+2]), 16'h0040);
        chk("R5 addr 3", int'(log_a[f0+3]), 16'h0041);
        chk("R2 data 3", int'(log_d[f0+3]), 8'h53);
      end
      chk("R6 latch cleared", int'(wel), 0);
    end

    // R3: write-enable followed by extra bits is discarded
    open_f(1'b0);
    bits(1'b0, 8'h06, 8);
    bits(1'b0, 8'h00, 1);
    close_f();
    chk("R3 extra bit keeps latch", int'(wel), 0);

    // R12: the trip pulses only ever came singly with their frames
    chk("R12 total set pulses", n_set, 2);
    chk("R12 total native pulses", n_nat, 2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule